// File: doc/BRIEF.md
# Branch fetch bus sequencer

This block drives the instruction-memory side of a small pipelined core for the three cycles a branch or branch-with-link instruction takes. A one-cycle start strobe hands it the branch instruction's own address, the already computed destination, a link request and the current instruction-set mode. The mode is either wide (4-byte instructions) or compact (2-byte instructions). For the next three cycles the block then produces the fetch address, access size, read/write and opcode-fetch strobes. It also produces a memory-request strobe and a sequential strobe, and these two run one cycle ahead: each describes the access of the following cycle.

The first cycle still prefetches past the branch, because it is too late to cancel that fetch. The second cycle fetches the destination and the third fetches the next instruction after it. When a link is asked for in wide mode, the return address goes to register 14 in cycle 2 through a register-file write port. In cycle 3 a second write lowers that value by four. In compact mode a link request is illegal: it raises an error and writes nothing. At the end of cycle 3 the block hands the next sequential fetch address back to the core.

Top module: `brfetch_seq`

## Requirements
- R1: While reset is held, and in every cycle the block is idle, the outputs are: busy_o=0, req_n_o=1, seq_o=0, opc_n_o=1, wr_o=0, size_o=0, fetch_addr_o=0, lr_we_o=0, link_err_o=0, done_o=0.
- R2: A start_i seen at a clock edge while idle makes busy_o high in exactly the three following cycles (cycles 1, 2, 3). Outside those cycles busy_o is low.
- R3: The step L is 4 in wide mode (compact_i=0) and 2 in compact mode. In cycle 1 fetch_addr_o is pc+2L. In all three cycles size_o is 2 (word) in wide mode and 1 (halfword) in compact mode.
- R4: In cycle 2 fetch_addr_o equals the target. In cycle 3 it equals target+L. All sums wrap modulo 2^32.
- R5: In cycle 1, req_n_o=0 and seq_o=0. In cycles 2 and 3, req_n_o=0 and seq_o=1.
- R6: In all three cycles wr_o=0 (a read) and opc_n_o=0 (an opcode fetch).
- R7: With link_i=1 in wide mode, cycle 2 has lr_we_o=1, lr_sel_o=14 and lr_data_o=pc+8. Cycle 3 has lr_we_o=1 and lr_data_o=pc+4, which is the first value minus 4.
- R8: With link_i=1 in compact mode, link_err_o is 1 in cycle 1 and 0 at all other times. lr_we_o stays 0 for the whole branch.
- R9: A start_i that arrives in cycles 1 to 3 is ignored. The branch in progress keeps its addresses, and the block is idle again in the cycle after cycle 3.
- R10: In cycle 3 only, done_o=1 and resume_addr_o equals target+2L.
- R11: With link_i=0, lr_we_o stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a branch sequence |
| pc_i | input | 32 | Address of the branch instruction |
| target_i | input | 32 | Computed destination address |
| link_i | input | 1 | Branch also writes the return address |
| compact_i | input | 1 | 1 = 2-byte instruction mode, 0 = 4-byte mode |
| busy_o | output | 1 | Sequence in progress (cycles 1 to 3) |
| fetch_addr_o | output | 32 | Address of this cycle's fetch |
| size_o | output | 2 | Access size: 2 word, 1 halfword, 0 idle |
| wr_o | output | 1 | 1 = write, 0 = read |
| opc_n_o | output | 1 | Active-low opcode-fetch strobe |
| req_n_o | output | 1 | Active-low request for the next cycle |
| seq_o | output | 1 | Next cycle's access is sequential |
| lr_we_o | output | 1 | Register-file write enable |
| lr_sel_o | output | 4 | Register index written (14) |
| lr_data_o | output | 32 | Value written |
| link_err_o | output | 1 | Link requested in compact mode |
| done_o | output | 1 | Last cycle of the sequence |
| resume_addr_o | output | 32 | Next sequential fetch address, valid with done_o |

## Verification
Every result follows the accepting clock edge by a fixed number of cycles. The cycle-1 fetch, the ahead-of-time non-sequential strobes and any link error come one cycle after the start strobe. The destination fetch and the first register write come after two cycles. The refill fetch, the corrected write and the resume address come after three. The bench queues one expected entry per cycle for each branch it issues. A monitor then compares one entry per clock, a few nanoseconds after the edge, and it expects the idle values whenever the queue is empty. A shifted strobe or an extra busy cycle therefore shows up as a mismatch in the cycle where it happens.

// File: rtl/brfetch_pkg.sv
// Shared types and constants for the branch fetch sequencer.
// Assumes: the access-size code and register index match the core's bus and register file.
package brfetch_pkg;

    // Sequencer phase: idle, then one state per bus cycle of the branch.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2,
        PH_THREE = 2'd3
    } br_phase_e;

    localparam logic [1:0] SZ_NONE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int unsigned REG_SEL_W = 4;
    localparam logic [REG_SEL_W-1:0] RET_REG = 4'd14;

endpackage

// File: rtl/brfetch_ctrl.sv
// Phase counter for the branch sequence.
// Accepts a start only when idle, then steps through three phases back to idle.
// Assumes: start is a single-cycle strobe; a start while busy is dropped.
module brfetch_ctrl
    import brfetch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    output br_phase_e phase_o,
    output logic      accept_o
);

    br_phase_e phase_q;
    br_phase_e phase_d;

    // Accept a new branch only while idle.
    assign accept_o = start_i && (phase_q == PH_IDLE);

    // Next-phase selection.
    always_comb begin
        unique case (phase_q)
            PH_IDLE:  phase_d = accept_o ? PH_ONE : PH_IDLE;
            PH_ONE:   phase_d = PH_TWO;
            PH_TWO:   phase_d = PH_THREE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/brfetch_ctx.sv
// Holds the operands of the accepted branch for the whole sequence.
// Assumes: operands are valid in the cycle start is accepted.
module brfetch_ctx #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              link_i,
    input  logic              compact_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              link_o,
    output logic              compact_o
);

    // Capture branch operands on acceptance; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o      <= '0;
            target_o  <= '0;
            link_o    <= 1'b0;
            compact_o <= 1'b0;
        end else if (load_i) begin
            pc_o      <= pc_i;
            target_o  <= target_i;
            link_o    <= link_i;
            compact_o <= compact_i;
        end
    end

endmodule

// File: rtl/brfetch_addr.sv
// Fetch-address and access-size generation per phase.
// Step L is 4 in wide mode and 2 in compact mode; all sums wrap.
// Assumes: operands are held stable by the context register.
module brfetch_addr
    import brfetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  br_phase_e         phase_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              compact_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [1:0]        size_o,
    output logic [ADDR_W-1:0] resume_addr_o,
    output logic [ADDR_W-1:0] ret_addr_o
);

    localparam logic [ADDR_W-1:0] STEP_WIDE    = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_COMPACT = ADDR_W'(2);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] pc_plus2;
    logic [ADDR_W-1:0] tgt_plus1;
    logic [ADDR_W-1:0] tgt_plus2;

    // Instruction length for the captured mode.
    assign step = compact_i ? STEP_COMPACT : STEP_WIDE;

    // Address sums used across the three cycles.
    assign pc_plus2  = pc_i + (step << 1);
    assign tgt_plus1 = target_i + step;
    assign tgt_plus2 = target_i + (step << 1);

    // Per-phase fetch address and size.
    always_comb begin
        unique case (phase_i)
            PH_ONE:   fetch_addr_o = pc_plus2;
            PH_TWO:   fetch_addr_o = target_i;
            PH_THREE: fetch_addr_o = tgt_plus1;
            default:  fetch_addr_o = '0;
        endcase
        size_o = (phase_i == PH_IDLE) ? SZ_NONE : (compact_i ? SZ_HALF : SZ_WORD);
    end

    assign resume_addr_o = tgt_plus2;
    assign ret_addr_o    = pc_plus2;

endmodule

// File: rtl/brfetch_link.sv
// Return-address write path: first write in phase two, corrected write in phase three.
// Flags a link request in compact mode as an error and suppresses both writes.
// Assumes: the register file applies writes in order, one per cycle.
module brfetch_link
    import brfetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned RET_ADJ = 4
) (
    input  br_phase_e             phase_i,
    input  logic                  link_i,
    input  logic                  compact_i,
    input  logic [ADDR_W-1:0]     ret_addr_i,
    output logic                  we_o,
    output logic [REG_SEL_W-1:0]  sel_o,
    output logic [ADDR_W-1:0]     data_o,
    output logic                  err_o
);

    localparam logic [ADDR_W-1:0] ADJ = ADDR_W'(RET_ADJ);

    logic link_ok;

    // Link writes are legal only in wide mode.
    assign link_ok = link_i && !compact_i;

    // Write enable, data and error per phase.
    always_comb begin
        we_o   = 1'b0;
        data_o = '0;
        err_o  = 1'b0;
        unique case (phase_i)
            PH_ONE: err_o = link_i && compact_i;
            PH_TWO: begin
                we_o   = link_ok;
                data_o = ret_addr_i;
            end
            PH_THREE: begin
                we_o   = link_ok;
                data_o = ret_addr_i - ADJ;
            end
            default: ;
        endcase
    end

    assign sel_o = RET_REG;

endmodule

// File: rtl/brfetch_seq.sv
// Top of the branch fetch sequencer: drives bus strobes for the three cycles
// of a branch, with request/sequential strobes one cycle ahead of their access.
// Assumes: target arithmetic is done outside and presented with start.
module brfetch_seq
    import brfetch_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    pc_i,
    input  logic [ADDR_W-1:0]    target_i,
    input  logic                 link_i,
    input  logic                 compact_i,
    output logic                 busy_o,
    output logic [ADDR_W-1:0]    fetch_addr_o,
    output logic [1:0]           size_o,
    output logic                 wr_o,
    output logic                 opc_n_o,
    output logic                 req_n_o,
    output logic                 seq_o,
    output logic                 lr_we_o,
    output logic [REG_SEL_W-1:0] lr_sel_o,
    output logic [ADDR_W-1:0]    lr_data_o,
    output logic                 link_err_o,
    output logic                 done_o,
    output logic [ADDR_W-1:0]    resume_addr_o
);

    br_phase_e         phase;
    logic              accept;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              link_q;
    logic              compact_q;
    logic [ADDR_W-1:0] ret_addr;

    brfetch_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .phase_o  (phase),
        .accept_o (accept)
    );

    brfetch_ctx #(.ADDR_W(ADDR_W)) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .pc_i      (pc_i),
        .target_i  (target_i),
        .link_i    (link_i),
        .compact_i (compact_i),
        .pc_o      (pc_q),
        .target_o  (tgt_q),
        .link_o    (link_q),
        .compact_o (compact_q)
    );

    brfetch_addr #(.ADDR_W(ADDR_W)) u_addr (
        .phase_i       (phase),
        .pc_i          (pc_q),
        .target_i      (tgt_q),
        .compact_i     (compact_q),
        .fetch_addr_o  (fetch_addr_o),
        .size_o        (size_o),
        .resume_addr_o (resume_addr_o),
        .ret_addr_o    (ret_addr)
    );

    brfetch_link #(.ADDR_W(ADDR_W)) u_link (
        .phase_i    (phase),
        .link_i     (link_q),
        .compact_i  (compact_q),
        .ret_addr_i (ret_addr),
        .we_o       (lr_we_o),
        .sel_o      (lr_sel_o),
        .data_o     (lr_data_o),
        .err_o      (link_err_o)
    );

    // Bus strobes: every active cycle is an opcode read; request and
    // sequential strobes announce the access of the following cycle.
    always_comb begin
        busy_o  = (phase != PH_IDLE);
        wr_o    = 1'b0;
        opc_n_o = !busy_o;
        req_n_o = !busy_o;
        seq_o   = (phase == PH_TWO) || (phase == PH_THREE);
        done_o  = (phase == PH_THREE);
    end

endmodule

// File: rtl/brfetch_chk.sv
// Assertion checker for brfetch_seq, attached by bind.
module brfetch_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic [ADDR_W-1:0] fetch_addr_o,
    input logic [1:0]        size_o,
    input logic              wr_o,
    input logic              opc_n_o,
    input logic              req_n_o,
    input logic              seq_o,
    input logic              lr_we_o,
    input logic [ADDR_W-1:0] lr_data_o,
    input logic              link_err_o,
    input logic              done_o
);

    logic [2:0] run_q;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 3'd0;
        else if (busy_o) run_q <= (run_q == 3'd7) ? run_q : run_q + 3'd1;
        else             run_q <= 3'd0;
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> run_q < 3'd3);

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && run_q != 3'd0) |-> run_q == 3'd3);

    assert_first_nonseq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_q == 3'd0) |-> (!req_n_o && !seq_o));

    assert_later_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_q != 3'd0) |-> (!req_n_o && seq_o));

    assert_opcode_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!wr_o && !opc_n_o && size_o != 2'd0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (req_n_o && !seq_o && opc_n_o && !lr_we_o && !link_err_o && !done_o));

    assert_refill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_q == 3'd2) |->
        fetch_addr_o == $past(fetch_addr_o) + ((size_o == 2'd1) ? ADDR_W'(2) : ADDR_W'(4)));

    assert_link_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we_o && busy_o && run_q == 3'd1) |=> (lr_we_o && lr_data_o == $past(lr_data_o) - ADDR_W'(4)));

    assert_err_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_err_o |=> !lr_we_o ##1 !lr_we_o);

    assert_done_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

bind brfetch_seq brfetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .fetch_addr_o (fetch_addr_o),
    .size_o       (size_o),
    .wr_o         (wr_o),
    .opc_n_o      (opc_n_o),
    .req_n_o      (req_n_o),
    .seq_o        (seq_o),
    .lr_we_o      (lr_we_o),
    .lr_data_o    (lr_data_o),
    .link_err_o   (link_err_o),
    .done_o       (done_o)
);

// File: tb/brfetch_seq_test.sv
module brfetch_seq_test;

    typedef struct {
        int          cyc;      // 0 idle, 1..3 branch cycle
        logic        busy;
        logic [31:0] addr;
        logic [1:0]  size;
        logic        req_n;
        logic        seq;
        logic        opc_n;
        logic        wr;
        logic        we;
        logic [31:0] data;
        logic        err;
        logic        done;
        logic [31:0] resume;
        bit          link_req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [31:0] target_i = '0;
    logic        link_i = 1'b0;
    logic        compact_i = 1'b0;
    logic        busy_o, wr_o, opc_n_o, req_n_o, seq_o, lr_we_o, link_err_o, done_o;
    logic [31:0] fetch_addr_o, lr_data_o, resume_addr_o;
    logic [1:0]  size_o;
    logic [3:0]  lr_sel_o;

    int tests = 0;
    int fails = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    brfetch_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i),
        .target_i(target_i), .link_i(link_i), .compact_i(compact_i),
        .busy_o(busy_o), .fetch_addr_o(fetch_addr_o), .size_o(size_o),
        .wr_o(wr_o), .opc_n_o(opc_n_o), .req_n_o(req_n_o), .seq_o(seq_o),
        .lr_we_o(lr_we_o), .lr_sel_o(lr_sel_o), .lr_data_o(lr_data_o),
        .link_err_o(link_err_o), .done_o(done_o), .resume_addr_o(resume_addr_o)
    );

    function automatic exp_t idle_item();
        exp_t e;
        e.cyc = 0; e.busy = 0; e.addr = 0; e.size = 0; e.req_n = 1; e.seq = 0;
        e.opc_n = 1; e.wr = 0; e.we = 0; e.data = 0; e.err = 0; e.done = 0;
        e.resume = 0; e.link_req = 0;
        return e;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Driver: start one branch at the current negedge and queue three expected cycles.
    task automatic issue(input logic [31:0] pc, input logic [31:0] tgt,
                         input logic lnk, input logic cmp, input bit poke);
        logic [31:0] l;
        exp_t e;
        l = cmp ? 32'd2 : 32'd4;
        pc_i = pc; target_i = tgt; link_i = lnk; compact_i = cmp; start_i = 1'b1;
        for (int c = 1; c <= 3; c++) begin
            e = idle_item();
            e.cyc = c; e.busy = 1; e.size = cmp ? 2'd1 : 2'd2;
            e.req_n = 0; e.seq = (c != 1); e.opc_n = 0; e.wr = 0;
            e.link_req = lnk;
            e.addr = (c == 1) ? pc + 2*l : (c == 2) ? tgt : tgt + l;
            e.err = (c == 1) && lnk && cmp;
            e.we = (c != 1) && lnk && !cmp;
            e.data = (c == 2) ? pc + 2*l : pc + 2*l - 32'd4;
            e.done = (c == 3);
            e.resume = tgt + 2*l;
            q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        if (poke) begin  // R9: start while busy must be ignored
            pc_i = 32'h5555_0000; target_i = 32'h6666_0000; link_i = 1'b1;
            compact_i = ~cmp; start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare one expected cycle shortly after every clock edge.
    initial begin
        exp_t e;
        string ta, tl;
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && !finished) begin
                e = (q.size() > 0) ? q.pop_front() : idle_item();
                if (e.cyc == 0) begin
                    ta = "R1"; tl = "R1";
                end else begin
                    ta = (e.cyc == 1) ? "R3" : "R4";
                    tl = e.err ? "R8" : (e.link_req ? "R7" : "R11");
                end
                check((e.cyc == 0) ? "R1" : "R2", "busy", busy_o, e.busy);
                check(ta, "addr", fetch_addr_o, e.addr);
                check((e.cyc == 0) ? "R1" : "R3", "size", size_o, e.size);
                check((e.cyc == 0) ? "R1" : "R5", "req_n", req_n_o, e.req_n);
                check((e.cyc == 0) ? "R1" : "R5", "seq", seq_o, e.seq);
                check((e.cyc == 0) ? "R1" : "R6", "opc_n", opc_n_o, e.opc_n);
                check((e.cyc == 0) ? "R1" : "R6", "wr", wr_o, e.wr);
                check(tl, "lr_we", lr_we_o, e.we);
                if (e.we) begin
                    check("R7", "lr_data", lr_data_o, e.data);
                    check("R7", "lr_sel", lr_sel_o, 32'd14);
                end
                check((e.cyc == 0) ? "R1" : "R8", "link_err", link_err_o, e.err);
                check((e.cyc == 0) ? "R1" : "R10", "done", done_o, e.done);
                if (e.done) check("R10", "resume", resume_addr_o, e.resume);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (2) @(posedge clk);
        mon_on = 1'b1;            // R1: idle values checked during reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        issue(32'h0000_1000, 32'h0000_2000, 1'b0, 1'b0, 1'b0);  // R11 plain wide
        issue(32'h0000_1000, 32'h0000_3000, 1'b1, 1'b0, 1'b0);  // R7 link wide
        issue(32'h0000_0100, 32'h0000_0200, 1'b0, 1'b1, 1'b0);  // R3 compact
        issue(32'h0000_0100, 32'h0000_0400, 1'b1, 1'b1, 1'b0);  // R8 link in compact
        issue(32'hFFFF_FFFC, 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0);  // R4 wrap
        issue(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0);  // R4 wrap compact
        issue(32'h0000_8000, 32'h0000_9000, 1'b0, 1'b0, 1'b1);  // R9 ignored start
        issue(32'h0000_A000, 32'h0000_B000, 1'b1, 1'b0, 1'b1);  // R9 with link
        repeat (3) @(negedge clk);
        finished = 1'b1;
        if (q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R2 leftover expected items actual=%0d expected=0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule